// File: doc/BRIEF.md
# Shadowed SRAM Store/Recall Engine

This block is a synchronous model of a byte-wide working SRAM backed by a full-size nonvolatile shadow array of the same depth. A host reads and writes the working array through a port with chip enable, output enable, write enable, an address and separate write and read data. Two request inputs trigger bulk transfers between the arrays. A store first erases the whole shadow to 0xFF and then programs it byte by byte from the working SRAM. A recall copies the shadow back over the working SRAM.

While a transfer runs, a busy flag is high, host reads return zero and host writes are dropped. A store ends with a parameterised dwell period that stands in for the programming time. Reset clears the working SRAM and the sequencer, but not the shadow, so a recall after reset brings back the last stored image. The depth is set by `AW`: `AW = 13` gives the 8,192-byte configuration, and the default is kept smaller so that it elaborates quickly.

Top module: `nvs_top`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `busy` is 0 and every working SRAM byte reads as 0x00.
- R2: When `ce`=1, `oe`=1, `we`=0 and `busy`=0, `rd_data` equals the working byte at `addr` in the same cycle, and it follows any change of `addr` with no other input change.
- R3: In every other case `rd_data` is 0x00. This includes a write (`ce`=1, `we`=1) with `oe` held at 1.
- R4: A write spans the consecutive cycles with `ce`=1 and `we`=1. The byte stored is `wdata` at `addr` from the last such cycle. It is committed when either enable drops and can be read from the following cycle.
- R5: `store_req`=1 while idle makes `busy` high from the next cycle for exactly 2·2^AW + DWELL cycles. The shadow is erased to 0xFF, programmed with the working SRAM contents, and the working SRAM is left unchanged.
- R6: `recall_req`=1 while idle makes `busy` high from the next cycle for exactly 2^AW cycles. Afterwards every working byte equals the shadow byte at the same address.
- R7: While `busy` is 1, host writes have no effect on the working SRAM and `rd_data` is 0x00.
- R8: `store_req` and `recall_req` seen while `busy` is 1 are ignored. No transfer follows the current one.
- R9: If `store_req` and `recall_req` are both high in the same idle cycle, a store runs and the recall is dropped.
- R10: The shadow contents survive reset. A recall issued after reset restores the image from the last store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Chip enable, active high |
| oe | input | 1 | Output enable, active high |
| we | input | 1 | Write enable, active high |
| addr | input | AW | Byte address |
| wdata | input | DW | Write data |
| rd_data | output | DW | Read data, zero when no read is active |
| store_req | input | 1 | Start a store (SRAM to shadow) |
| recall_req | input | 1 | Start a recall (shadow to SRAM) |
| busy | output | 1 | Transfer in progress |

## Verification
A sequencer that is stuck or counts wrongly shows up at once as a `busy` pulse of the wrong length, measured to the cycle against 2·2^AW + DWELL for a store or 2^AW for a recall. A re-triggered transfer shows up as `busy` rising again right after it fell. A bad copy or a missed erase-and-program step appears only when the bytes are read back, which is after the next recall, so each transfer is followed by a full read sweep of every address. A host-write latch that holds stale data appears on the first read of the written address in the cycle after commit.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ERASE,
        ST_PROG,
        ST_DWELL,
        ST_RECALL
    } nvs_state_e;
endpackage

// File: rtl/nvs_bank.sv
// Byte array with one synchronous write port and one combinational read port.
module nvs_bank #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          clr,
    input  logic          wen,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdat,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdat
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (clr) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wen) begin
            mem[waddr] <= wdat;
        end
    end

    assign rdat = mem[raddr];
endmodule

// File: rtl/nvs_host.sv
// Holds the address and data of an open host write and commits the byte when
// the write closes.
module nvs_host #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ce,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          busy,
    output logic          commit,
    output logic [AW-1:0] c_addr,
    output logic [DW-1:0] c_data
);
    typedef struct packed {
        logic          act;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
    } host_t;

    host_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (busy) begin
            st_d.act = 1'b0;
        end else if (ce && we) begin
            st_d.act = 1'b1;
            st_d.a   = addr;
            st_d.d   = wdata;
        end else begin
            st_d.act = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign commit = st_q.act && !(ce && we) && !busy;
    assign c_addr = st_q.a;
    assign c_data = st_q.d;
endmodule

// File: rtl/nvs_seq.sv
// Transfer sequencer: erase, program and dwell for a store; one pass for a recall.
module nvs_seq
    import nvs_pkg::*;
#(
    parameter int AW    = 10,
    parameter int DWELL = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          store_req,
    input  logic          recall_req,
    output logic          busy,
    output logic [AW-1:0] seq_addr,
    output logic          sh_we,
    output logic          sh_erase,
    output logic          sram_rec_we
);
    localparam int            DWW     = $clog2(DWELL + 1);
    localparam logic [AW-1:0] LAST    = '1;
    localparam logic [DWW-1:0] DW_LAST = DWW'(DWELL - 1);

    typedef struct packed {
        nvs_state_e     st;
        logic [AW-1:0]  cnt;
        logic [DWW-1:0] dw;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            ST_IDLE: begin
                if (store_req) begin
                    s_d.st  = ST_ERASE;
                    s_d.cnt = '0;
                end else if (recall_req) begin
                    s_d.st  = ST_RECALL;
                    s_d.cnt = '0;
                end
            end
            ST_ERASE: begin
                if (s_q.cnt == LAST) begin
                    s_d.st  = ST_PROG;
                    s_d.cnt = '0;
                end else begin
                    s_d.cnt = s_q.cnt + AW'(1);
                end
            end
            ST_PROG: begin
                if (s_q.cnt == LAST) begin
                    s_d.st = ST_DWELL;
                    s_d.dw = '0;
                end else begin
                    s_d.cnt = s_q.cnt + AW'(1);
                end
            end
            ST_DWELL: begin
                if (s_q.dw == DW_LAST) s_d.st = ST_IDLE;
                else                   s_d.dw = s_q.dw + DWW'(1);
            end
            ST_RECALL: begin
                if (s_q.cnt == LAST) s_d.st = ST_IDLE;
                else                 s_d.cnt = s_q.cnt + AW'(1);
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.st  <= ST_IDLE;
            s_q.cnt <= '0;
            s_q.dw  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy        = (s_q.st != ST_IDLE);
    assign seq_addr    = s_q.cnt;
    assign sh_we       = (s_q.st == ST_ERASE) || (s_q.st == ST_PROG);
    assign sh_erase    = (s_q.st == ST_ERASE);
    assign sram_rec_we = (s_q.st == ST_RECALL);
endmodule

// File: rtl/nvs_top.sv
module nvs_top #(
    parameter int AW    = 10,
    parameter int DW    = 8,
    parameter int DWELL = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ce,
    input  logic          oe,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rd_data,
    input  logic          store_req,
    input  logic          recall_req,
    output logic          busy
);
    logic          host_commit;
    logic [AW-1:0] host_addr;
    logic [DW-1:0] host_data;
    logic [AW-1:0] seq_addr;
    logic          sh_we, sh_erase, sram_rec_we;
    logic [DW-1:0] sram_rdat, sh_rdat;
    logic          sram_wen;
    logic [AW-1:0] sram_waddr, sram_raddr;
    logic [DW-1:0] sram_wdat, sh_wdat;

    nvs_seq #(.AW(AW), .DWELL(DWELL)) u_seq (
        .clk(clk), .rst(rst), .store_req(store_req), .recall_req(recall_req),
        .busy(busy), .seq_addr(seq_addr), .sh_we(sh_we), .sh_erase(sh_erase),
        .sram_rec_we(sram_rec_we)
    );

    nvs_host #(.AW(AW), .DW(DW)) u_host (
        .clk(clk), .rst(rst), .ce(ce), .we(we), .addr(addr), .wdata(wdata),
        .busy(busy), .commit(host_commit), .c_addr(host_addr), .c_data(host_data)
    );

    assign sram_wen   = host_commit || sram_rec_we;
    assign sram_waddr = sram_rec_we ? seq_addr : host_addr;
    assign sram_wdat  = sram_rec_we ? sh_rdat  : host_data;
    assign sram_raddr = busy ? seq_addr : addr;
    assign sh_wdat    = sh_erase ? '1 : sram_rdat;

    nvs_bank #(.AW(AW), .DW(DW)) u_sram (
        .clk(clk), .clr(rst), .wen(sram_wen), .waddr(sram_waddr), .wdat(sram_wdat),
        .raddr(sram_raddr), .rdat(sram_rdat)
    );

    nvs_bank #(.AW(AW), .DW(DW)) u_shadow (
        .clk(clk), .clr(1'b0), .wen(sh_we), .waddr(seq_addr), .wdat(sh_wdat),
        .raddr(seq_addr), .rdat(sh_rdat)
    );

    assign rd_data = (ce && oe && !we && !busy) ? sram_rdat : '0;
endmodule

// File: rtl/nvs_chk.sv
module nvs_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          we,
    input logic          store_req,
    input logic          recall_req,
    input logic          busy,
    input logic [DW-1:0] rd_data,
    input logic          commit,
    input logic          sh_we,
    input logic          sram_rec_we
);
    AST_RST_IDLE: assert property (@(posedge clk) rst |=> !busy); // R1

    AST_WR_HIDES_RD: assert property (@(posedge clk) disable iff (rst)
        we |-> rd_data == '0); // R3

    AST_STORE_START: assert property (@(posedge clk) disable iff (rst)
        (!busy && store_req) |=> (busy && sh_we)); // R5

    AST_RECALL_START: assert property (@(posedge clk) disable iff (rst)
        (!busy && recall_req && !store_req) |=> (busy && sram_rec_we)); // R6

    AST_BUSY_NO_HOST_WR: assert property (@(posedge clk) disable iff (rst)
        busy |-> (!commit && rd_data == '0)); // R7

    AST_ONE_TRANSFER: assert property (@(posedge clk) disable iff (rst)
        !(sh_we && sram_rec_we)); // R9
endmodule

bind nvs_top nvs_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst(rst), .we(we), .store_req(store_req), .recall_req(recall_req),
    .busy(busy), .rd_data(rd_data), .commit(host_commit), .sh_we(sh_we),
    .sram_rec_we(sram_rec_we)
);

// File: tb/nvs_top_tb.sv
module nvs_top_tb;
    localparam int AW    = 4;
    localparam int DW    = 8;
    localparam int DWELL = 3;
    localparam int N     = 1 << AW;

    logic clk = 1'b0, rst = 1'b1;
    logic ce = 1'b0, oe = 1'b0, we = 1'b0, store_req = 1'b0, recall_req = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rd_data;
    logic busy;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [DW-1:0] exp_mem [N];
    logic [DW-1:0] snap [N];

    always #4 clk = ~clk;

    nvs_top #(.AW(AW), .DW(DW), .DWELL(DWELL)) u_dut (
        .clk(clk), .rst(rst), .ce(ce), .oe(oe), .we(we), .addr(addr),
        .wdata(wdata), .rd_data(rd_data), .store_req(store_req),
        .recall_req(recall_req), .busy(busy)
    );

    function automatic logic [DW-1:0] pat(int a, int s);
        return DW'(a * 37 + s);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    task automatic wr(int a, logic [DW-1:0] d);
        @(negedge clk); ce = 1; we = 1; oe = 0; addr = AW'(a); wdata = d;
        @(negedge clk); ce = 0; we = 0;
        exp_mem[a] = d;
    endtask

    task automatic rd_chk(int a, logic [DW-1:0] e, string req);
        @(negedge clk); ce = 1; oe = 1; we = 0; addr = AW'(a);
        #1 chk(req, 32'(rd_data), 32'(e));
    endtask

    task automatic sweep(string req);
        for (int a = 0; a < N; a++) rd_chk(a, exp_mem[a], req);
        @(negedge clk); ce = 0; oe = 0;
    endtask

    // Start a transfer, measure busy, poke the host and the request pins mid-run.
    task automatic run_op(bit s, bit r, int exp_len, string req);
        int len;
        @(negedge clk); store_req = s; recall_req = r;
        @(negedge clk); store_req = 0; recall_req = 0;
        len = 0;
        while (busy && len < 1000) begin
            len++;
            if (len == 2) begin ce = 1; we = 1; addr = '0; wdata = 8'h5A; end
            if (len == 3) begin ce = 0; we = 0; end
            if (len == 4) begin store_req = 1; recall_req = 1; end
            if (len == 5) begin
                store_req = 0; recall_req = 0; ce = 1; oe = 1; addr = AW'(1);
                #1 chk("R7", 32'(rd_data), 32'h0);
            end
            if (len == 6) begin ce = 0; oe = 0; end
            @(negedge clk);
        end
        chk(req, 32'(len), 32'(exp_len));
        @(negedge clk);
        chk("R8", 32'(busy), 32'h0); // no second transfer after the poke
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", 32'(busy), 32'h0);
        rst = 0;
        for (int a = 0; a < N; a++) exp_mem[a] = '0;
        sweep("R1");

        for (int a = 0; a < N; a++) wr(a, pat(a, 1));
        for (int a = N - 1; a >= 0; a--) rd_chk(a, exp_mem[a], "R2");

        @(negedge clk); oe = 0; #1 chk("R3", 32'(rd_data), 32'h0);
        @(negedge clk); ce = 0; oe = 1; #1 chk("R3", 32'(rd_data), 32'h0);

        // write with oe held: output off, last data wins (R3, R4)
        @(negedge clk); ce = 1; oe = 1; we = 1; addr = AW'(5); wdata = 8'hC3;
        #1 chk("R3", 32'(rd_data), 32'h0);
        @(negedge clk); wdata = 8'h3C;
        #1 chk("R3", 32'(rd_data), 32'h0);
        @(negedge clk); we = 0;
        @(negedge clk); #1 chk("R4", 32'(rd_data), 32'h3C);
        exp_mem[5] = 8'h3C;

        // write closed by chip enable
        @(negedge clk); oe = 0; ce = 1; we = 1; addr = AW'(6); wdata = 8'h11;
        @(negedge clk); ce = 0;
        @(negedge clk); we = 0;
        exp_mem[6] = 8'h11;
        rd_chk(6, 8'h11, "R4");
        @(negedge clk); ce = 0; oe = 0;

        // store, SRAM untouched by the blocked write
        for (int a = 0; a < N; a++) snap[a] = exp_mem[a];
        run_op(1, 0, 2 * N + DWELL, "R5");
        rd_chk(0, exp_mem[0], "R7");
        sweep("R5");

        // overwrite then recall
        for (int a = 0; a < N; a++) wr(a, pat(a, 2));
        run_op(0, 1, N, "R6");
        for (int a = 0; a < N; a++) exp_mem[a] = snap[a];
        sweep("R6");

        // simultaneous requests: store runs, SRAM keeps new data
        for (int a = 0; a < N; a++) wr(a, pat(a, 3));
        run_op(1, 1, 2 * N + DWELL, "R9");
        sweep("R9");

        // reset keeps the shadow
        @(negedge clk); rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        for (int a = 0; a < N; a++) snap[a] = exp_mem[a];
        for (int a = 0; a < N; a++) exp_mem[a] = '0;
        sweep("R1");
        run_op(0, 1, N, "R10");
        for (int a = 0; a < N; a++) exp_mem[a] = snap[a];
        sweep("R10");

        finish_run();
    end
endmodule